// File: doc/BRIEF.md
# UART DMA Request Controller

This block sits next to the transmit and receive FIFOs of a UART. It holds one 16-bit control register, written and read through a simple register port, and it turns the FIFO levels into DMA request lines. It also raises an interrupt flag when a receive timeout is routed away from DMA, drives a soft-reset strobe to the rest of the UART, and generates the auto-RTS flow-control output.

The DMA requests depend on several things: the per-direction enables, a per-direction request mode that works together with the DMA-mode bit of the FIFO control register, and a 1- or 2-byte transfer width. The receive timeout can serve either as an extra receive DMA source or as an interrupt. The serial shifter, FIFO storage, baud generator and DMA engine stay outside and drive this block's inputs.

Top module: `uart_dma_req_ctrl`

## Requirements
- R1: The control register resets to zero. A write stores `reg_wdata[7:0]`. `reg_rdata[15:8]` always reads zero, and `reg_rdata[7:0]` returns the stored bits.
- R2: Bit 0 enables `tx_dma_req` and bit 1 enables `rx_dma_req`. The cycle after a clock edge at which an enable bit is 0, its line is low.
- R3: Mode 0 for a direction applies when `fifo_dma_mode` is 0 or that direction's mode bit is 0. The receive mode bit is bit 3 and the transmit mode bit is bit 2. In mode 0, receive requests when `rx_level` is at least one transfer unit, and transmit requests when `tx_free` is at least one transfer unit.
- R4: Mode 1 applies when `fifo_dma_mode` is 1 and the direction's mode bit is 1. In mode 1, receive requests when `rx_level` is at least both `rx_trig` and one unit, and transmit requests only when `tx_free` equals DEPTH (the transmit FIFO is empty).
- R5: Bit 5 selects the transfer unit: 0 gives 1 byte, 1 gives 2 bytes. A receive timeout with bit 4 clear makes a timeout pending. A pending timeout requests receive DMA while `rx_level` is nonzero, even if only 1 byte remains. The pending timeout clears when `rx_level` reaches zero.
- R6: With bit 4 set, a receive timeout sets `tout_irq` and raises no DMA request. `tout_irq` stays set until `rx_pop` is seen. A timeout in the same cycle as `rx_pop` wins.
- R7: `soft_rst` follows bit 7. While it is 1, the request lines, `tout_irq` and the pending timeout are cleared. Register bits 6:0 keep their values.
- R8: `rts_n` goes high (deasserted) once `rx_level` reaches the threshold, and goes low again below it. The threshold is `rx_trig` when bit 6 is 0 and DEPTH-1 when bit 6 is 1.
- R9: All outputs except `reg_rdata` and `soft_rst` are registered. A request rises or drops in the cycle after its condition changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| fifo_dma_mode | input | 1 | DMA-mode bit of the FIFO control register |
| rx_level | input | LW | Receive FIFO fill level |
| rx_trig | input | LW | Receive trigger level |
| tx_free | input | LW | Transmit FIFO free entries |
| rx_timeout | input | 1 | Receive timeout event pulse |
| rx_pop | input | 1 | Receive FIFO read strobe |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tout_irq | output | 1 | Receive timeout interrupt flag |
| soft_rst | output | 1 | Soft reset to the rest of the UART |
| rts_n | output | 1 | Auto-RTS output, active low |

## Verification
The checker applies some rules on every cycle. Reserved read bits stay zero. A disabled direction never requests. An empty receive FIFO or a full transmit FIFO gives no request. Soft reset silences every output flag. The interrupt flag holds until it is acknowledged. The RTS output follows the empty and full extremes of the receive FIFO. The exact request thresholds depend on the transfer width, the request mode, the trigger level and the RTS mode, and only the bench's sweep over every register setting and fill level can show them. The timeout routing, the timeout request at a single byte, and the one-cycle latency are shown by directed sequences.

// File: rtl/uart_dma_req_ctrl.sv
module uart_dma_req_ctrl #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          fifo_dma_mode,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] rx_trig,
  input  logic [LW-1:0] tx_free,
  input  logic          rx_timeout,
  input  logic          rx_pop,
  output logic          tx_dma_req,
  output logic          rx_dma_req,
  output logic          tout_irq,
  output logic          soft_rst,
  output logic          rts_n
);

  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [LW-1:0] NEAR = LW'(DEPTH - 1);

  logic [7:0] ctrl;
  logic       pend_q, tx_q, rx_q, irq_q, rts_q;
  logic       unused_wbits;

  assign unused_wbits = ^reg_wdata[15:8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctrl <= '0;
    else if (reg_wr) ctrl <= reg_wdata[7:0];

  wire tx_en    = ctrl[0];
  wire rx_en    = ctrl[1];
  wire tout_sel = ctrl[4];
  wire srst     = ctrl[7];

  wire [LW-1:0] unit = ctrl[5] ? LW'(2) : LW'(1);
  wire rx_m1 = fifo_dma_mode & ctrl[3];
  wire tx_m1 = fifo_dma_mode & ctrl[2];

  wire rx_has  = rx_level != '0;
  wire rx_base = rx_m1 ? (rx_level >= rx_trig && rx_level >= unit)
                       : (rx_level >= unit);
  wire rx_cond = rx_base | (pend_q & rx_has & ~tout_sel);
  wire tx_cond = tx_m1 ? (tx_free == FULL) : (tx_free >= unit);

  wire [LW-1:0] rts_thr = ctrl[6] ? NEAR : rx_trig;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
      rts_q  <= 1'b0;
    end else begin
      if (srst || !rx_has || tout_sel) pend_q <= 1'b0;
      else if (rx_timeout)             pend_q <= 1'b1;

      if (srst)                        irq_q <= 1'b0;
      else if (rx_timeout && tout_sel) irq_q <= 1'b1;
      else if (rx_pop)                 irq_q <= 1'b0;

      tx_q  <= ~srst & tx_en & tx_cond;
      rx_q  <= ~srst & rx_en & rx_cond;
      rts_q <= rx_level >= rts_thr;
    end

  assign reg_rdata  = {8'h00, ctrl};
  assign soft_rst   = srst;
  assign tx_dma_req = tx_q;
  assign rx_dma_req = rx_q;
  assign tout_irq   = irq_q;
  assign rts_n      = rts_q;

endmodule

// File: rtl/uart_dma_req_ctrl_chk.sv
module uart_dma_req_ctrl_chk #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   reg_rdata,
  input logic [LW-1:0] rx_level,
  input logic [LW-1:0] rx_trig,
  input logic [LW-1:0] tx_free,
  input logic          rx_pop,
  input logic          tx_dma_req,
  input logic          rx_dma_req,
  input logic          tout_irq,
  input logic          soft_rst,
  input logic          rts_n
);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[15:8] == 8'h00);

  a_r2_tx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[0] |=> !tx_dma_req);

  a_r2_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[1] |=> !rx_dma_req);

  a_r3_rx_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level == '0 |=> !rx_dma_req);

  a_r3_tx_full: assert property (@(posedge clk) disable iff (!rst_n)
    tx_free == '0 |=> !tx_dma_req);

  a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_irq && !rx_pop && !soft_rst) |=> tout_irq);

  a_r6_irq_routed: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[4] && !tout_irq) |=> !tout_irq);

  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!tx_dma_req && !rx_dma_req && !tout_irq));

  a_r8_rts_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0 && rx_trig != '0) |=> !rts_n);

  a_r8_rts_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level == LW'(DEPTH) |=> rts_n);

endmodule

bind uart_dma_req_ctrl uart_dma_req_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .rx_level(rx_level),
  .rx_trig(rx_trig), .tx_free(tx_free), .rx_pop(rx_pop),
  .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .tout_irq(tout_irq),
  .soft_rst(soft_rst), .rts_n(rts_n)
);

// File: tb/uart_dma_req_ctrl_bench.sv
module uart_dma_req_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic fifo_dma_mode = 1'b0;
  logic [LW-1:0] rx_level = '0, rx_trig = LW'(1), tx_free = '0;
  logic rx_timeout = 1'b0, rx_pop = 1'b0;
  logic tx_dma_req, rx_dma_req, tout_irq, soft_rst, rts_n;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_dma_req_ctrl #(.DEPTH(DEPTH)) u_uart_dma_req_ctrl (.*);

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reg_rdata, 0, "R1 reset rdata");
    chk({tx_dma_req, rx_dma_req, tout_irq, soft_rst}, 0, "R1 reset outputs");
    rst_n = 1'b1;

    // R1 reserved bits, R7 soft reset strobe and silencing
    wr(16'hFFFF);
    chk(reg_rdata, 16'h00FF, "R1 reserved readback");
    chk(soft_rst, 1, "R7 strobe");
    rx_level = LW'(DEPTH); tx_free = LW'(DEPTH); rx_trig = LW'(1);
    step; step;
    chk({tx_dma_req, rx_dma_req}, 0, "R7 requests held low");
    wr(16'hA57F);
    chk(reg_rdata, 16'h007F, "R7 bits kept, R1 write");
    chk(soft_rst, 0, "R7 release");

    // sweep: R2 R3 R4 R8
    for (int c = 0; c < 128; c++) begin
      wr(16'(c));
      for (int m = 0; m < 2; m++)
        for (int ti = 0; ti < 4; ti++)
          for (int lvl = 0; lvl <= DEPTH; lvl++) begin
            int trig, txf, unit, thr;
            bit erx, etx, erts, rxm1, txm1;
            string rtag, ttag;
            trig = (ti == 0) ? 1 : (ti == 1) ? 4 : (ti == 2) ? 8 : 14;
            txf  = (lvl * 7) % (DEPTH + 1);
            fifo_dma_mode = m[0];
            rx_level = LW'(lvl); rx_trig = LW'(trig); tx_free = LW'(txf);
            step;
            unit = c[5] ? 2 : 1;
            rxm1 = m[0] && c[3];
            txm1 = m[0] && c[2];
            erx = c[1] && (rxm1 ? (lvl >= trig && lvl >= unit) : (lvl >= unit));
            etx = c[0] && (txm1 ? (txf == DEPTH) : (txf >= unit));
            thr = c[6] ? DEPTH - 1 : trig;
            erts = lvl >= thr;
            rtag = !c[1] ? "R2 rx gate" : rxm1 ? "R4 rx mode1" : "R3 rx mode0";
            ttag = !c[0] ? "R2 tx gate" : txm1 ? "R4 tx mode1" : "R3 tx mode0";
            chk(rx_dma_req, erx, rtag);
            chk(tx_dma_req, etx, ttag);
            chk(rts_n, erts, "R8 rts");
          end
    end

    // R9 latency: request rises and drops one edge after the condition
    fifo_dma_mode = 1'b0;
    wr(16'h0001);
    tx_free = '0; step;
    chk(tx_dma_req, 0, "R9 idle");
    tx_free = LW'(5); step;
    chk(tx_dma_req, 1, "R9 rise after one edge");
    tx_free = '0; step;
    chk(tx_dma_req, 0, "R9 drop after one edge");

    // R5 timeout as DMA source with 2-byte width, one byte left
    wr(16'h0023);
    rx_level = LW'(1); rx_trig = LW'(8); step;
    chk(rx_dma_req, 0, "R5 one byte no request");
    rx_timeout = 1'b1; step;
    rx_timeout = 1'b0;
    chk(tout_irq, 0, "R5 no irq when routed to DMA");
    step;
    chk(rx_dma_req, 1, "R5 timeout request at one byte");
    step;
    chk(rx_dma_req, 1, "R5 request held");
    rx_level = '0; step; step;
    chk(rx_dma_req, 0, "R5 drop on empty");
    rx_level = LW'(1); step; step;
    chk(rx_dma_req, 0, "R5 pending cleared");

    // R6 timeout routed to interrupt
    wr(16'h0033);
    rx_timeout = 1'b1; step;
    rx_timeout = 1'b0;
    chk(tout_irq, 1, "R6 irq set");
    step; step; step;
    chk(tout_irq, 1, "R6 irq held");
    chk(rx_dma_req, 0, "R6 no DMA request");
    rx_pop = 1'b1; step;
    rx_pop = 1'b0;
    chk(tout_irq, 0, "R6 cleared by read");
    rx_timeout = 1'b1; rx_pop = 1'b1; step;
    rx_timeout = 1'b0; rx_pop = 1'b0;
    chk(tout_irq, 1, "R6 timeout wins over read");

    // R7 soft reset clears the flag
    wr(16'h00B3);
    step;
    chk(tout_irq, 0, "R7 irq cleared");
    wr(16'h0033);
    chk(tout_irq, 0, "R7 irq stays clear");
    chk(reg_rdata, 16'h0033, "R7 register kept");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule